// File: doc/BRIEF.md
# Prescaled Reload Interval Timer

This block raises an interrupt request at a fixed period. An 8-bit down-counter counts source ticks. When it passes zero it reloads from a software-written reload register and sets a sticky request flag. The flag stays set until software clears it.

There are three count sources. The first is the instruction clock, which is one tick every three system clocks. The second is the output of a shared 8-bit reloadable prescaler that divides the instruction clock. The third is that prescaler output divided by two. With the prescaler, the period is the product of the two (reload + 1) terms and the factor of three. The prescaler has its own start bit.

The usual setup sequence is as follows:
1. Stop the timer.
2. Pick the source.
3. Write the reload values.
4. Clear the flag.
5. Start the prescaler and then the timer.

The control register bit 3 has no function here. It only reads back as written.

Top module: `prescaled_reload_timer`

## Requirements
- R1: After reset, the control readback is 0, the prescaler run readback is 0, the counter value is 0 and the request flag is 0.
- R2: With control bits [1:0] = 00 (instruction clock) and run bit 2 = 1, a timer reload value N gives a flag set every 3*(N+1) system clocks.
- R3: With control bits [1:0] = 01 (prescaler output) and the prescaler running with reload value P, the flag sets every 3*(P+1)*(N+1) system clocks.
- R4: With control bits [1:0] = 10 or 11 (prescaler output halved), the flag sets every 6*(P+1)*(N+1) system clocks.
- R5: While control bit 2 is 0, the counter value does not change unless the reload register is written.
- R6: A write of the timer reload register while bit 2 is 0 also loads the counter with the written value on the next clock.
- R7: The request flag sets on each underflow and holds until flag_clr is pulsed. A set in the same cycle as a clear wins.
- R8: While the prescaler run bit is 0, a timer on a prescaler-derived source does not count.
- R9: All four control register bits read back as last written, including the unused bit 3.
- R10: The prescaler run bit reads back as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Write strobe for the timer control register |
| ctrl_wdata | input | 4 | Control value: [1:0] source, [2] run, [3] spare |
| ctrl_rdata | output | 4 | Control register readback |
| pre_run_we | input | 1 | Write strobe for the prescaler run bit |
| pre_run_wdata | input | 1 | Prescaler run value |
| pre_run | output | 1 | Prescaler run readback |
| reload_we | input | 1 | Write strobe for the timer reload register |
| reload_wdata | input | 8 | Timer reload value |
| pre_reload_we | input | 1 | Write strobe for the prescaler reload register |
| pre_reload_wdata | input | 8 | Prescaler reload value |
| flag_clr | input | 1 | Clears the request flag |
| count | output | 8 | Current timer counter value |
| irq_flag | output | 1 | Sticky interrupt request flag |

## Verification
A divider or prescaler phase that is off by one shows up as a wrong interval between flag sets. The error appears within the first full period after start, so the bench times the gap between consecutive flag sets across many random reload and source combinations. A counter that moves while it should be held shows at the count port on the very next clock. A lost or ignored reload write shows there too. A wrongly cleared or stuck flag becomes visible within one period.

// File: rtl/prt_pkg.sv
package prt_pkg;
    localparam int CNT_W    = 8;
    localparam int PRE_W    = 8;
    localparam int INST_DIV = 3;

    typedef enum logic [1:0] {
        SRC_INST     = 2'b00,
        SRC_PRE      = 2'b01,
        SRC_HALF     = 2'b10,
        SRC_HALF_ALT = 2'b11
    } src_sel_e;
endpackage

// File: rtl/prt_inst_div.sv
module prt_inst_div #(
    parameter int DIV = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [DW-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.cnt == DW'(DIV - 1)) s_d.cnt = '0;
        else                         s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick_o = (s_q.cnt == DW'(DIV - 1));
endmodule

// File: rtl/prt_prescaler.sv
module prt_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         run_i,
    input  logic         reload_we_i,
    input  logic [W-1:0] reload_i,
    output logic         pulse_o,
    output logic         half_o
);
    typedef struct packed {
        logic [W-1:0] rld;
        logic [W-1:0] cnt;
        logic         half;
    } st_t;

    st_t  s_d, s_q;
    logic under;

    assign under = run_i && tick_i && (s_q.cnt == '0);

    always_comb begin
        s_d = s_q;
        if (reload_we_i) s_d.rld = reload_i;
        if (!run_i) begin
            s_d.cnt = reload_we_i ? reload_i : s_q.rld;
        end else if (tick_i) begin
            s_d.cnt = under ? s_q.rld : s_q.cnt - 1'b1;
        end
        if (under) s_d.half = ~s_q.half;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pulse_o = under;
    assign half_o  = under && s_q.half;
endmodule

// File: rtl/prt_timer_core.sv
module prt_timer_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         src_tick_i,
    input  logic         run_i,
    input  logic         reload_we_i,
    input  logic [W-1:0] reload_i,
    input  logic         flag_clr_i,
    output logic [W-1:0] count_o,
    output logic         flag_o
);
    typedef struct packed {
        logic [W-1:0] rld;
        logic [W-1:0] cnt;
        logic         flag;
    } st_t;

    st_t  s_d, s_q;
    logic under;

    assign under = run_i && src_tick_i && (s_q.cnt == '0);

    always_comb begin
        s_d = s_q;
        if (reload_we_i) s_d.rld = reload_i;
        if (run_i) begin
            if (src_tick_i) s_d.cnt = under ? s_q.rld : s_q.cnt - 1'b1;
        end else if (reload_we_i) begin
            s_d.cnt = reload_i;
        end
        if (flag_clr_i) s_d.flag = 1'b0;
        if (under)      s_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count_o = s_q.cnt;
    assign flag_o  = s_q.flag;
endmodule

// File: rtl/prescaled_reload_timer.sv
module prescaled_reload_timer
    import prt_pkg::*;
#(
    parameter int TW  = CNT_W,
    parameter int PW  = PRE_W,
    parameter int DIV = INST_DIV
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we,
    input  logic [3:0]    ctrl_wdata,
    output logic [3:0]    ctrl_rdata,
    input  logic          pre_run_we,
    input  logic          pre_run_wdata,
    output logic          pre_run,
    input  logic          reload_we,
    input  logic [TW-1:0] reload_wdata,
    input  logic          pre_reload_we,
    input  logic [PW-1:0] pre_reload_wdata,
    input  logic          flag_clr,
    output logic [TW-1:0] count,
    output logic          irq_flag
);
    typedef struct packed {
        logic [3:0] ctrl;
        logic       prun;
    } st_t;

    st_t      s_d, s_q;
    logic     inst_tick, pre_pulse, pre_half, src_tick;
    src_sel_e sel;

    always_comb begin
        s_d = s_q;
        if (ctrl_we)    s_d.ctrl = ctrl_wdata;
        if (pre_run_we) s_d.prun = pre_run_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sel = src_sel_e'(s_q.ctrl[1:0]);

    always_comb begin
        unique case (sel)
            SRC_INST:     src_tick = inst_tick;
            SRC_PRE:      src_tick = pre_pulse;
            SRC_HALF,
            SRC_HALF_ALT: src_tick = pre_half;
            default:      src_tick = 1'b0;
        endcase
    end

    prt_inst_div #(.DIV(DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (inst_tick)
    );

    prt_prescaler #(.W(PW)) u_pre (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (inst_tick),
        .run_i       (s_q.prun),
        .reload_we_i (pre_reload_we),
        .reload_i    (pre_reload_wdata),
        .pulse_o     (pre_pulse),
        .half_o      (pre_half)
    );

    prt_timer_core #(.W(TW)) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_tick_i  (src_tick),
        .run_i       (s_q.ctrl[2]),
        .reload_we_i (reload_we),
        .reload_i    (reload_wdata),
        .flag_clr_i  (flag_clr),
        .count_o     (count),
        .flag_o      (irq_flag)
    );

    assign ctrl_rdata = s_q.ctrl;
    assign pre_run    = s_q.prun;
endmodule

// File: rtl/prt_checker.sv
module prt_checker #(
    parameter int TW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctrl_we,
    input logic [3:0]    ctrl_wdata,
    input logic [3:0]    ctrl_rdata,
    input logic          pre_run_we,
    input logic          pre_run_wdata,
    input logic          pre_run,
    input logic          reload_we,
    input logic [TW-1:0] reload_wdata,
    input logic          flag_clr,
    input logic [TW-1:0] count,
    input logic          irq_flag
);
    // R7
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag && !flag_clr |=> irq_flag);

    // R5
    p_hold_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rdata[2] && !ctrl_we && !reload_we |=> $stable(count));

    // R6
    p_load_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reload_we && !ctrl_rdata[2] && !ctrl_we |=> count == $past(reload_wdata));

    // R9
    p_ctrl_readback_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> ctrl_rdata == $past(ctrl_wdata));

    // R10
    p_prun_readback_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pre_run_we |=> pre_run == $past(pre_run_wdata));

    // R8
    p_pre_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_run && !pre_run_we && ctrl_rdata[1:0] != 2'b00 && !ctrl_we && !reload_we
        |=> $stable(count));
endmodule

bind prescaled_reload_timer prt_checker #(.TW(TW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_we       (ctrl_we),
    .ctrl_wdata    (ctrl_wdata),
    .ctrl_rdata    (ctrl_rdata),
    .pre_run_we    (pre_run_we),
    .pre_run_wdata (pre_run_wdata),
    .pre_run       (pre_run),
    .reload_we     (reload_we),
    .reload_wdata  (reload_wdata),
    .flag_clr      (flag_clr),
    .count         (count),
    .irq_flag      (irq_flag)
);

// File: tb/prescaled_reload_timer_tb.sv
module prescaled_reload_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [3:0] ctrl_wdata = '0;
    logic [3:0] ctrl_rdata;
    logic       pre_run_we = 1'b0;
    logic       pre_run_wdata = 1'b0;
    logic       pre_run;
    logic       reload_we = 1'b0;
    logic [7:0] reload_wdata = '0;
    logic       pre_reload_we = 1'b0;
    logic [7:0] pre_reload_wdata = '0;
    logic       flag_clr = 1'b0;
    logic [7:0] count;
    logic       irq_flag;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    prescaled_reload_timer u_dut (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
        .pre_run_we(pre_run_we), .pre_run_wdata(pre_run_wdata), .pre_run(pre_run),
        .reload_we(reload_we), .reload_wdata(reload_wdata),
        .pre_reload_we(pre_reload_we), .pre_reload_wdata(pre_reload_wdata),
        .flag_clr(flag_clr), .count(count), .irq_flag(irq_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_period(input int src, input int n, input int p);
        if (src == 0)      return 3 * (n + 1);
        else if (src == 1) return 3 * (p + 1) * (n + 1);
        else               return 6 * (p + 1) * (n + 1);
    endfunction

    task automatic wr_ctrl(input logic [3:0] v);
        ctrl_wdata = v; ctrl_we = 1'b1;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic wr_prun(input logic v);
        pre_run_wdata = v; pre_run_we = 1'b1;
        @(negedge clk); pre_run_we = 1'b0;
    endtask

    task automatic wr_reload(input logic [7:0] v);
        reload_wdata = v; reload_we = 1'b1;
        @(negedge clk); reload_we = 1'b0;
    endtask

    task automatic wr_pre_reload(input logic [7:0] v);
        pre_reload_wdata = v; pre_reload_we = 1'b1;
        @(negedge clk); pre_reload_we = 1'b0;
    endtask

    task automatic clr_flag();
        flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic setup(input logic [1:0] src, input int n, input int p, input logic spare);
        wr_ctrl({spare, 1'b0, src});
        wr_prun(1'b0);
        wr_reload(8'(n));
        wr_pre_reload(8'(p));
        clr_flag();
        wr_prun(1'b1);
        wr_ctrl({spare, 1'b1, src});
    endtask

    // returns cycles between two consecutive flag sets
    task automatic measure(output int period);
        int w = 0;
        while (!irq_flag && w < 20000) begin @(negedge clk); w++; end
        flag_clr = 1'b1;
        period = 0;
        do begin
            @(negedge clk);
            flag_clr = 1'b0;
            period++;
        end while (!irq_flag && period < 20000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int per;
        logic [7:0] snap;
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ctrl", ctrl_rdata, 0);
        chk("R1 prun", pre_run, 0);
        chk("R1 count", count, 0);
        chk("R1 flag", irq_flag, 0);

        // R9 readback including spare bit
        wr_ctrl(4'b1011);
        chk("R9 ctrl readback", ctrl_rdata, 11);
        // R10
        wr_prun(1'b1);
        chk("R10 prun readback", pre_run, 1);

        // R6 load while stopped
        wr_ctrl(4'b0000);
        wr_reload(8'd37);
        chk("R6 count loaded", count, 37);
        // R5 hold while stopped
        repeat (20) @(negedge clk);
        chk("R5 count held", count, 37);

        // R8 prescaler stopped blocks prescaled source
        wr_prun(1'b0);
        wr_ctrl(4'b0101);
        snap = count;
        repeat (60) @(negedge clk);
        chk("R8 count frozen", count, snap);
        chk("R8 no flag", irq_flag, 0);

        // directed corners R2 R3 R4
        setup(2'b00, 0, 0, 1'b0);   measure(per); chk("R2 N=0", per, exp_period(0, 0, 0));
        setup(2'b00, 166, 0, 1'b1); measure(per); chk("R2 N=166", per, exp_period(0, 166, 0));
        setup(2'b01, 0, 0, 1'b0);   measure(per); chk("R3 N=0 P=0", per, exp_period(1, 0, 0));
        setup(2'b01, 5, 15, 1'b0);  measure(per); chk("R3 N=5 P=15", per, exp_period(1, 5, 15));
        setup(2'b10, 3, 2, 1'b0);   measure(per); chk("R4 code 10", per, exp_period(2, 3, 2));
        setup(2'b11, 0, 0, 1'b1);   measure(per); chk("R4 code 11", per, exp_period(2, 0, 0));

        // R7 sticky then clear
        repeat (40) @(negedge clk);
        chk("R7 flag sticky", irq_flag, 1);
        wr_ctrl(4'b0011);
        clr_flag();
        chk("R7 flag cleared", irq_flag, 0);

        // random mix
        for (int i = 0; i < 24; i++) begin
            logic [1:0] s = 2'($urandom_range(0, 3));
            int n = $urandom_range(0, 15);
            int p = $urandom_range(0, 7);
            setup(s, n, p, 1'($urandom_range(0, 1)));
            measure(per);
            if (s == 2'b00)      chk("R2 random", per, exp_period(0, n, p));
            else if (s == 2'b01) chk("R3 random", per, exp_period(1, n, p));
            else                 chk("R4 random", per, exp_period(2, n, p));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule